// File: doc/BRIEF.md
# SCL Period Generator with Clock-Stretch Awareness

This block produces the clock line waveform for an I2C bus master. Two programmable counts set the length of the low phase and the high phase of SCL. A prescaler sits in front of the counters. It advances them once per input clock, or once every two input clocks. Each count is nine bits wide. The lowest eight bits come from one byte input per phase, and the ninth bit comes from a separate single-bit input that is honoured only when extended counts are enabled.

The low phase is timed from the edge on which the master starts pulling SCL low. The generator does not wait to see the line fall. When the low phase ends, the master releases SCL and waits until the sensed line level reads high. This absorbs the rise time and any clock stretching by a slave. Only then does the high counter run. The bit sequencer receives a one-cycle tick each time a high phase ends, together with a phase flag. START/STOP generation and data shifting are handled elsewhere.

The generator runs only while the channel is enabled and a transfer is active. At any other time it releases SCL and clears its counters.

Top module: `scl_period_gen`

## Requirements
- R1: While `chan_en` and `xfer_active` are not both high, `scl_drive_low`, `phase_high` and `bit_tick` are 0 from the next clock onwards. When both go high again, `scl_drive_low` rises on the next clock and the low phase lasts its full programmed length.
- R2: The low phase (`scl_drive_low` = 1) lasts exactly effective_low × step cycles, counted from the drive edge. The length is the same even if `scl_in` reads high throughout.
- R3: After the low phase, SCL stays released with `phase_high` = 0 until `scl_in` is sampled high. `phase_high` rises on the clock after that sample, so with an instant rise the wait lasts 1 cycle and with a slave holding the line it lasts as long as the hold. The high counter does not advance while waiting, so the high phase length does not depend on the hold.
- R4: The high phase (`phase_high` = 1) lasts exactly effective_high × step cycles. When it ends, `scl_drive_low` rises on the next clock.
- R5: step is 1 input clock per count when `div2_sel` = 0 and 2 input clocks per count when `div2_sel` = 1.
- R6: Each effective count is {ninth bit, byte}, where the ninth bit is `low_ext` or `high_ext`. When `ext_cnt_en` = 0 the ninth bit is ignored, which limits the count to 255. When `ext_cnt_en` = 1 the count reaches 511.
- R7: A count value of 0 is treated as 1, so no phase has zero length.
- R8: `bit_tick` is high for exactly one cycle: the first cycle of each low phase that follows a high phase. It stays 0 in the first low phase after idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chan_en | input | 1 | Channel enable |
| xfer_active | input | 1 | A transfer is in progress |
| div2_sel | input | 1 | Prescaler: 0 = 1 clock per count, 1 = 2 clocks per count |
| ext_cnt_en | input | 1 | Honour the ninth count bits |
| low_byte | input | 8 | Low-phase count, bits 7:0 |
| low_ext | input | 1 | Low-phase count, bit 8 |
| high_byte | input | 8 | High-phase count, bits 7:0 |
| high_ext | input | 1 | High-phase count, bit 8 |
| scl_in | input | 1 | Sensed SCL line level |
| scl_drive_low | output | 1 | 1 = pull SCL low, 0 = release |
| bit_tick | output | 1 | One-cycle pulse when a high phase ends |
| phase_high | output | 1 | 1 during the timed high phase |

## Verification
A counter loaded with the wrong value, or stepped at the wrong rate, changes the number of cycles that `scl_drive_low` or `phase_high` stays high. This shows up within one SCL period as a wrong run length. A state machine that leaves the wait state without seeing `scl_in` high, or that lets the counter drift while the line is held, shortens the stretched period or the high phase that follows it. A missing clear on disable shows up as an outlier: the first low phase after re-enable has the wrong length. A misplaced tick is off by one cycle against the low-phase entry edge.

// File: rtl/scl_gen_pkg.sv
`timescale 1ns/1ps
package scl_gen_pkg;
   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_LOW  = 2'd1,
      PH_WAIT = 2'd2,
      PH_HIGH = 2'd3
   } scl_phase_e;
endpackage

// File: rtl/scl_count_sel.sv
`timescale 1ns/1ps
// Builds the effective count for one phase: byte plus optional ninth bit,
// with zero promoted to one.
module scl_count_sel #(
   parameter int BYTE_W = 8,
   parameter int CNT_W  = 9
) (
   input  logic [BYTE_W-1:0] byte_val,
   input  logic              ext_bit,
   input  logic              ext_en,
   output logic [CNT_W-1:0]  eff_cnt
);
   localparam int EXT_W = CNT_W - BYTE_W;

   generate
      if (EXT_W != 1) begin : g_bad_width
         $error("scl_count_sel: CNT_W must be BYTE_W + 1");
      end
   endgenerate

   logic [CNT_W-1:0] raw;

   always_comb begin
      raw     = {(ext_en & ext_bit), byte_val};
      eff_cnt = (raw == '0) ? CNT_W'(1) : raw;
   end
endmodule

// File: rtl/scl_prescale.sv
`timescale 1ns/1ps
// Produces the count step enable: every clock, or every second clock.
module scl_prescale #(
   parameter bit HAS_DIV2 = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   input  logic div2,
   output logic step
);
   generate
      if (HAS_DIV2) begin : g_div
         logic half_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       half_q <= 1'b0;
            else if (restart) half_q <= 1'b0;
            else              half_q <= ~half_q;
         end
         assign step = div2 ? half_q : 1'b1;

         AST_DIV2_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
            (div2 && step) |=> (!step || !div2)); // R5
      end else begin : g_nodiv
         assign step = 1'b1;
      end
   endgenerate
endmodule

// File: rtl/scl_phase_cnt.sv
`timescale 1ns/1ps
// Down counter for the current phase; done fires on the final step.
module scl_phase_cnt #(
   parameter int CNT_W = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             count_en,
   input  logic             step,
   output logic [CNT_W-1:0] cnt,
   output logic             done
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                cnt <= '0;
      else if (clear)                            cnt <= '0;
      else if (load)                             cnt <= load_val;
      else if (count_en && step && (cnt > ONE))  cnt <= cnt - ONE;
   end

   assign done = count_en && step && (cnt <= ONE);

   AST_CNT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      count_en |-> (cnt != '0)); // R7
endmodule

// File: rtl/scl_period_gen.sv
`timescale 1ns/1ps
module scl_period_gen #(
   parameter int BYTE_W   = 8,
   parameter int CNT_W    = 9,
   parameter bit HAS_DIV2 = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              chan_en,
   input  logic              xfer_active,
   input  logic              div2_sel,
   input  logic              ext_cnt_en,
   input  logic [BYTE_W-1:0] low_byte,
   input  logic              low_ext,
   input  logic [BYTE_W-1:0] high_byte,
   input  logic              high_ext,
   input  logic              scl_in,
   output logic              scl_drive_low,
   output logic              bit_tick,
   output logic              phase_high
);
   import scl_gen_pkg::*;

   scl_phase_e       state_q, state_d;
   logic             run, load, clear, count_en, step, done, tick_q;
   logic [CNT_W-1:0] eff_low, eff_high, load_val, cnt;

   scl_count_sel #(.BYTE_W(BYTE_W), .CNT_W(CNT_W)) u_sel_low (
      .byte_val(low_byte), .ext_bit(low_ext), .ext_en(ext_cnt_en), .eff_cnt(eff_low));

   scl_count_sel #(.BYTE_W(BYTE_W), .CNT_W(CNT_W)) u_sel_high (
      .byte_val(high_byte), .ext_bit(high_ext), .ext_en(ext_cnt_en), .eff_cnt(eff_high));

   scl_prescale #(.HAS_DIV2(HAS_DIV2)) u_pre (
      .clk(clk), .rst_n(rst_n), .restart(load | clear), .div2(div2_sel), .step(step));

   scl_phase_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .clear(clear), .load(load), .load_val(load_val),
      .count_en(count_en), .step(step), .cnt(cnt), .done(done));

   assign run      = chan_en & xfer_active;
   assign clear    = ~run;
   assign count_en = (state_q == PH_LOW) || (state_q == PH_HIGH);
   assign load_val = (state_q == PH_WAIT) ? eff_high : eff_low;

   always_comb begin
      state_d = state_q;
      load    = 1'b0;
      case (state_q)
         PH_IDLE: begin
            state_d = PH_LOW;
            load    = 1'b1;
         end
         PH_LOW: if (done) state_d = PH_WAIT;
         PH_WAIT: if (scl_in) begin
            state_d = PH_HIGH;
            load    = 1'b1;
         end
         PH_HIGH: if (done) begin
            state_d = PH_LOW;
            load    = 1'b1;
         end
         default: state_d = PH_IDLE;
      endcase
      if (!run) begin
         state_d = PH_IDLE;
         load    = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= PH_IDLE;
         tick_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         tick_q  <= run && (state_q == PH_HIGH) && done;
      end
   end

   assign scl_drive_low = (state_q == PH_LOW);
   assign phase_high    = (state_q == PH_HIGH);
   assign bit_tick      = tick_q;

   AST_IDLE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (!scl_drive_low && !phase_high && !bit_tick)); // R1

   AST_HIGH_AFTER_SENSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(phase_high) |-> $past(scl_in)); // R3

   AST_WAIT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == PH_WAIT && !scl_in && run) |=> ($stable(cnt) && !phase_high)); // R3

   AST_TICK_AT_LOW_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      bit_tick |-> (scl_drive_low && $past(phase_high))); // R8
endmodule

// File: tb/scl_period_gen_tb.sv
`timescale 1ns/1ps
module scl_period_gen_tb;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic chan_en = 1'b0, xfer_active = 1'b0, div2_sel = 1'b0, ext_cnt_en = 1'b0;
   logic [7:0] low_byte = 8'd3, high_byte = 8'd2;
   logic low_ext = 1'b0, high_ext = 1'b0;
   logic hold = 1'b0, stuck_hi = 1'b0;
   logic scl_in, scl_drive_low, bit_tick, phase_high;
   int errors = 0, checks = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   assign scl_in = stuck_hi | (~scl_drive_low & ~hold);

   scl_period_gen u_dut (
      .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .xfer_active(xfer_active),
      .div2_sel(div2_sel), .ext_cnt_en(ext_cnt_en), .low_byte(low_byte),
      .low_ext(low_ext), .high_byte(high_byte), .high_ext(high_ext),
      .scl_in(scl_in), .scl_drive_low(scl_drive_low), .bit_tick(bit_tick),
      .phase_high(phase_high));

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic set_cfg(input int lo, input bit lb, input int hi, input bit hb,
                          input bit ext, input bit d2);
      @(negedge clk);
      low_byte = 8'(lo); low_ext = lb; high_byte = 8'(hi); high_ext = hb;
      ext_cnt_en = ext; div2_sel = d2;
   endtask

   // Measures one full period starting at the next low-phase entry.
   task automatic measure(input int dly, output int nl, output int nw, output int nh,
                          output int tk, output int tk_after);
      @(negedge clk);
      while (scl_drive_low) @(negedge clk);
      while (!scl_drive_low) @(negedge clk);
      nl = 0;
      while (scl_drive_low) begin nl++; @(negedge clk); end
      nw = 0;
      while (!phase_high) begin nw++; hold = (nw < dly); @(negedge clk); end
      hold = 1'b0;
      nh = 0;
      while (phase_high) begin nh++; @(negedge clk); end
      tk = int'(bit_tick && scl_drive_low);
      @(negedge clk);
      tk_after = int'(bit_tick);
   endtask

   task automatic t_reset;
      @(negedge clk);
      chk("R1 reset drive", int'(scl_drive_low), 0);
      chk("R1 reset phase", int'(phase_high), 0);
      chk("R1 reset tick", int'(bit_tick), 0);
   endtask

   task automatic t_basic;
      int nl, nw, nh, tk, ta;
      set_cfg(3, 0, 2, 0, 0, 0);
      chan_en = 1'b1; xfer_active = 1'b1;
      measure(0, nl, nw, nh, tk, ta);
      chk("R2 low length div1", nl, 3);
      chk("R3 wait instant rise", nw, 1);
      chk("R4 high length div1", nh, 2);
      chk("R8 tick at low entry", tk, 1);
      chk("R8 tick one cycle", ta, 0);
   endtask

   task automatic t_div2;
      int nl, nw, nh, tk, ta;
      set_cfg(4, 0, 3, 0, 0, 1);
      measure(0, nl, nw, nh, tk, ta);
      chk("R5 low div2", nl, 8);
      chk("R5 high div2", nh, 6);
   endtask

   task automatic t_ext;
      int nl, nw, nh, tk, ta;
      set_cfg(5, 1, 2, 1, 1, 0);
      measure(0, nl, nw, nh, tk, ta);
      chk("R6 low nine bits", nl, 261);
      chk("R6 high nine bits", nh, 258);
      set_cfg(5, 1, 2, 1, 0, 0);
      measure(0, nl, nw, nh, tk, ta);
      chk("R6 low ninth bit ignored", nl, 5);
      chk("R6 high ninth bit ignored", nh, 2);
   endtask

   task automatic t_zero;
      int nl, nw, nh, tk, ta;
      set_cfg(0, 0, 0, 0, 1, 1);
      measure(0, nl, nw, nh, tk, ta);
      chk("R7 zero low", nl, 2);
      chk("R7 zero high", nh, 2);
   endtask

   task automatic t_stretch;
      int nl, nw, nh, tk, ta;
      set_cfg(3, 0, 4, 0, 0, 0);
      measure(6, nl, nw, nh, tk, ta);
      chk("R3 stretched wait", nw, 6);
      chk("R3 high unaffected by stretch", nh, 4);
      chk("R2 low under stretch", nl, 3);
   endtask

   task automatic t_stuck_sense;
      int nl, nw, nh, tk, ta;
      stuck_hi = 1'b1;
      measure(0, nl, nw, nh, tk, ta);
      chk("R2 low timed from drive", nl, 3);
      chk("R3 wait with line high", nw, 1);
      stuck_hi = 1'b0;
   endtask

   task automatic t_disable;
      int n;
      set_cfg(6, 0, 2, 0, 0, 0);
      @(negedge clk);
      while (scl_drive_low) @(negedge clk);
      while (!scl_drive_low) @(negedge clk);
      @(negedge clk);
      xfer_active = 1'b0;
      @(negedge clk);
      chk("R1 release after inactive", int'(scl_drive_low), 0);
      chk("R1 phase after inactive", int'(phase_high), 0);
      repeat (3) @(negedge clk);
      chk("R1 stays released", int'(scl_drive_low | phase_high | bit_tick), 0);
      chan_en = 1'b0; xfer_active = 1'b1;
      repeat (2) @(negedge clk);
      chk("R1 channel disabled released", int'(scl_drive_low), 0);
      chan_en = 1'b1;
      @(negedge clk);
      chk("R1 drive on resume", int'(scl_drive_low), 1);
      chk("R8 no tick after idle", int'(bit_tick), 0);
      n = 0;
      while (scl_drive_low) begin n++; @(negedge clk); end
      chk("R1 full low after resume", n, 6);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset();
      t_basic();
      t_div2();
      t_ext();
      t_zero();
      set_cfg(3, 0, 4, 0, 0, 0);
      t_stretch();
      t_stuck_sense();
      t_disable();
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         errors++; checks++;
         $display("FAIL watchdog R1-timeline: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule